// File: doc/BRIEF.md
# Keyed Write-Once Watchdog Timer

This block is a watchdog timer that software configures once and then keeps alive by writing a fixed key value. It has two byte-wide registers on a simple synchronous write bus. The first is a configuration register. It holds a two-bit action field and a five-bit exponent that sets the timeout length. The second is a restart register that takes the keep-alive key. Once configured, an internal counter advances on every clock. When the counter reaches the end of the selected period, the block raises an overflow event. Depending on the action field, that event becomes a one-cycle interrupt-request pulse, a one-cycle reset-request pulse, or nothing at all.

The configuration register is write-once: a lock flag set by the first write protects it until the next system reset. Misuse is treated as a fault. A second configuration write, or any restart value other than the key, forces an overflow event at once, unless the timer is stopped. After every overflow, whether natural or forced, the counter starts again from zero, so a neglected watchdog keeps firing at its period. The lock flag is brought out as a status pin for test.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the configuration register (select 0) reads 0x67: action field bits [6:5] = 11 (reset request), exponent field bits [4:0] = 7. The lock output is 0 and both request outputs are 0.
- R2: The first write to the configuration register (reg_sel = 0) after reset stores all 8 bits, which then read back unchanged. The write sets the lock output to 1 and restarts the counter from zero.
- R3: While locked, a configuration write leaves the register contents unchanged and restarts the counter. When the action is not stop, it also forces an overflow event, whose request pulse is high in the cycle after the write edge.
- R4: Writing exactly 0xAC to the restart register (reg_sel = 1) restarts the counter from zero and produces no request pulse.
- R5: Writing any value other than 0xAC to the restart register restarts the counter. When the action is not stop, it also forces an overflow event, visible in the cycle after the write edge.
- R6: Action field encoding: 00 stop, 01 pulses irq_pulse_o on each overflow event, and 10 or 11 pulse rst_pulse_o on each overflow event.
- R7: With action 00 the block never pulses either request output, including after a second configuration write or a wrong key.
- R8: The period, with exponent E and base B (default 4), is 2^(E+B) clocks. The request pulse is high after the 2^(E+B)-th rising edge following the last counter restart. The counter then restarts, so an unattended timer fires periodically.
- R9: Each request pulse lasts one cycle for a natural overflow, and the two request outputs are never high together.
- R10: The lock output stays 1 until the next reset, and only reset clears it. The restart register always reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_sel | input | 1 | Register select: 0 configuration, 1 restart |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| irq_pulse_o | output | 1 | One-cycle non-maskable interrupt request |
| rst_pulse_o | output | 1 | One-cycle reset request |
| lock_o | output | 1 | Configuration lock flag |

## Verification
A counter left uncleared by a key or a misuse write shows as a request pulse at the wrong cycle. The bench sees that within one period, because each request pulse is compared cycle by cycle against a reference count. A wrongly set or cleared lock flag shows in one of two ways at the next configuration write: a missing forced pulse, or a changed readback, both visible the cycle after the write edge. A wrong action decode sends an overflow to the other request output, and this is seen at the first overflow.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

   typedef enum logic [1:0] {
      ACT_STOP  = 2'b00,
      ACT_IRQ   = 2'b01,
      ACT_RST_A = 2'b10,
      ACT_RST_B = 2'b11
   } wd_action_e;

   function automatic logic act_running(input wd_action_e a);
      return a != ACT_STOP;
   endfunction

   function automatic logic act_is_irq(input wd_action_e a);
      return a == ACT_IRQ;
   endfunction

   function automatic logic act_is_rst(input wd_action_e a);
      return (a == ACT_RST_A) || (a == ACT_RST_B);
   endfunction

endpackage

// File: rtl/wdt_keyed_regs.sv
module wdt_keyed_regs
   import wdt_keyed_pkg::*;
#(
   parameter int          REG_W   = 8,
   parameter int          SEL_W   = 5,
   parameter int          ACT_LSB = 5,
   parameter logic [7:0]  KEY     = 8'hAC,
   parameter logic [7:0]  RST_VAL = 8'h67
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             sel,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output wd_action_e       act_o,
   output logic [SEL_W-1:0] csel_o,
   output logic             lock_o,
   output logic             misuse_o,
   output logic             touch_o
);

   logic [REG_W-1:0] cfg_q;
   logic             lock_q;
   logic             wr_cfg;
   logic             wr_key;

   assign wr_cfg = wr && !sel;
   assign wr_key = wr && sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= REG_W'(RST_VAL);
         lock_q <= 1'b0;
      end else if (wr_cfg && !lock_q) begin
         cfg_q  <= wdata;
         lock_q <= 1'b1;
      end
   end

   assign rdata    = sel ? '0 : cfg_q;
   assign act_o    = wd_action_e'(cfg_q[ACT_LSB+1:ACT_LSB]);
   assign csel_o   = cfg_q[SEL_W-1:0];
   assign lock_o   = lock_q;
   assign misuse_o = (wr_cfg && lock_q) || (wr_key && (wdata != REG_W'(KEY)));
   assign touch_o  = wr_cfg || wr_key;

endmodule

// File: rtl/wdt_keyed_term.sv
module wdt_keyed_term #(
   parameter int CNT_W      = 35,
   parameter int SEL_W      = 5,
   parameter int BASE_EXP   = 4,
   parameter int TERM_STYLE = 0
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [SEL_W-1:0] csel,
   output logic             terminal
);

   localparam int EXP_W = $clog2(CNT_W + 1) + 1;

   logic [EXP_W-1:0] exp_v;
   assign exp_v = EXP_W'(csel) + EXP_W'(BASE_EXP);

   generate
      if (TERM_STYLE == 0) begin : g_mask
         logic [CNT_W-1:0] mask;
         for (genvar i = 0; i < CNT_W; i++) begin : g_bit
            assign mask[i] = EXP_W'(i) < exp_v;
         end
         assign terminal = &(cnt | ~mask);
      end else begin : g_cmp
         logic [CNT_W-1:0] limit;
         assign limit    = (CNT_W'(1) << exp_v) - CNT_W'(1);
         assign terminal = (cnt == limit);
      end
   endgenerate

endmodule

// File: rtl/wdt_keyed_count.sv
module wdt_keyed_count #(
   parameter int CNT_W = 35
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clear,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (run)
         cnt <= cnt + CNT_W'(1);
   end

endmodule

// File: rtl/wdt_keyed_fire.sv
module wdt_keyed_fire
   import wdt_keyed_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       evt,
   input  wd_action_e act,
   output logic       irq_o,
   output logic       rst_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
         rst_o <= 1'b0;
      end else begin
         irq_o <= evt && act_is_irq(act);
         rst_o <= evt && act_is_rst(act);
      end
   end

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
   import wdt_keyed_pkg::*;
#(
   parameter int          SEL_W      = 5,
   parameter int          BASE_EXP   = 4,
   parameter int          ACT_LSB    = 5,
   parameter logic [7:0]  KEY        = 8'hAC,
   parameter logic [7:0]  RST_VAL    = 8'h67,
   parameter int          TERM_STYLE = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic       reg_sel,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       irq_pulse_o,
   output logic       rst_pulse_o,
   output logic       lock_o
);

   localparam int REG_W   = 8;
   localparam int MAX_EXP = (1 << SEL_W) - 1 + BASE_EXP;
   localparam int CNT_W   = MAX_EXP;

   generate
      if (SEL_W < 1 || ACT_LSB < SEL_W || ACT_LSB + 2 > REG_W) begin : g_bad_fields
         $error("wdt_keyed: field layout does not fit the register");
      end
      if (BASE_EXP < 1) begin : g_bad_base
         $error("wdt_keyed: BASE_EXP must be at least 1");
      end
      if (TERM_STYLE != 0 && TERM_STYLE != 1) begin : g_bad_style
         $error("wdt_keyed: TERM_STYLE must be 0 or 1");
      end
   endgenerate

   wd_action_e       act;
   logic [SEL_W-1:0] csel;
   logic             misuse;
   logic             touch;
   logic [CNT_W-1:0] cnt;
   logic             terminal;
   logic             running;
   logic             forced;
   logic             natural;
   logic             evt;

   wdt_keyed_regs #(
      .REG_W  (REG_W),
      .SEL_W  (SEL_W),
      .ACT_LSB(ACT_LSB),
      .KEY    (KEY),
      .RST_VAL(RST_VAL)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .sel     (reg_sel),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .act_o   (act),
      .csel_o  (csel),
      .lock_o  (lock_o),
      .misuse_o(misuse),
      .touch_o (touch)
   );

   wdt_keyed_term #(
      .CNT_W     (CNT_W),
      .SEL_W     (SEL_W),
      .BASE_EXP  (BASE_EXP),
      .TERM_STYLE(TERM_STYLE)
   ) u_term (
      .cnt     (cnt),
      .csel    (csel),
      .terminal(terminal)
   );

   assign running = act_running(act);
   assign forced  = misuse && running;
   assign natural = terminal && running;
   assign evt     = forced || natural;

   wdt_keyed_count #(
      .CNT_W(CNT_W)
   ) u_count (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (running),
      .clear(touch || evt),
      .cnt  (cnt)
   );

   wdt_keyed_fire u_fire (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (evt),
      .act  (act),
      .irq_o(irq_pulse_o),
      .rst_o(rst_pulse_o)
   );

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
   import wdt_keyed_pkg::*;
#(
   parameter int         SEL_W = 5,
   parameter logic [7:0] KEY   = 8'hAC
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             reg_sel,
   input logic [7:0]       reg_wdata,
   input wd_action_e       act,
   input logic [SEL_W-1:0] csel,
   input logic             lock,
   input logic             irq,
   input logic             rst
);

   // R9: the two requests never coincide
   assert_one_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq, rst}));

   // R10: lock only falls through reset
   assert_lock_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock);

   // R3: locked configuration does not change, and a rewrite fires
   assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> ($stable(act) && $stable(csel)));

   assert_rewrite_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_sel && lock && act != ACT_STOP) |=> (irq || rst));

   // R5: wrong key fires
   assert_bad_key_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel && reg_wdata != KEY && act != ACT_STOP) |=> (irq || rst));

   // R7: stopped timer stays quiet
   assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_STOP) |=> !(irq || rst));

endmodule

bind wdt_keyed wdt_keyed_chk #(
   .SEL_W(SEL_W),
   .KEY  (KEY)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_sel  (reg_sel),
   .reg_wdata(reg_wdata),
   .act      (act),
   .csel     (csel),
   .lock     (lock_o),
   .irq      (irq_pulse_o),
   .rst      (rst_pulse_o)
);

// File: tb/wdt_keyed_test.sv
module wdt_keyed_test;

   localparam int CLK_PERIOD = 10;
   localparam int BASE       = 4;
   localparam logic [7:0] KEY = 8'hAC;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_sel = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq_pulse_o;
   logic       rst_pulse_o;
   logic       lock_o;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_keyed uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .irq_pulse_o(irq_pulse_o),
      .rst_pulse_o(rst_pulse_o),
      .lock_o     (lock_o)
   );

   function automatic int period_of(input logic [4:0] e);
      return 1 << (int'(e) + BASE);
   endfunction

   function automatic logic exp_irq(input logic [1:0] act, input logic evt);
      return evt && (act == 2'b01);
   endfunction

   function automatic logic exp_rst(input logic [1:0] act, input logic evt);
      return evt && act[1];
   endfunction

   task automatic check(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n   = 1'b0;
      reg_wr  = 1'b0;
      reg_sel = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic bus_write(input logic s, input logic [7:0] d);
      @(negedge clk);
      reg_sel   = s;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic read_reg(input logic s, output logic [7:0] v);
      reg_sel = s;
      #1;
      v = reg_rdata;
   endtask

   // counts negedges until the wanted pulse; stray counts the other request
   task automatic wait_pulse(input bit want_rst, input int limit, output int n, output int stray);
      n = 0;
      stray = 0;
      forever begin
         @(negedge clk);
         n++;
         if ((want_rst ? irq_pulse_o : rst_pulse_o) === 1'b1) stray++;
         if ((want_rst ? rst_pulse_o : irq_pulse_o) === 1'b1) break;
         if (n > limit) break;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL R8 watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int n, stray;

      // R1 reset state
      do_reset();
      read_reg(1'b0, v);
      check("R1", "cfg reset value", v, 8'h67);
      check("R1", "lock after reset", lock_o, 0);
      check("R1", "irq after reset", irq_pulse_o, 0);
      check("R1", "rst after reset", rst_pulse_o, 0);

      // R8/R6 default configuration: reset action, exponent 7
      wait_pulse(1'b1, 3000, n, stray);
      check("R8", "default period", n, period_of(5'd7));
      check("R6", "default gives no irq", stray, 0);
      @(negedge clk);
      check("R9", "reset pulse one cycle", rst_pulse_o, 0);

      // R2 first write: irq action, exponent 0
      do_reset();
      bus_write(1'b0, 8'h20);
      check("R2", "lock set", lock_o, 1);
      read_reg(1'b0, v);
      check("R2", "cfg readback", v, 8'h20);
      wait_pulse(1'b0, 100, n, stray);
      check("R8", "irq period e0", n, period_of(5'd0));
      check("R6", "irq action gives no reset", stray, 0);
      @(negedge clk);
      check("R9", "irq pulse one cycle", irq_pulse_o, 0);

      // R3 second configuration write
      repeat (3) @(negedge clk);
      bus_write(1'b0, 8'h41);
      check("R3", "rewrite forces irq", irq_pulse_o, 1);
      read_reg(1'b0, v);
      check("R3", "rewrite ignored", v, 8'h20);
      wait_pulse(1'b0, 100, n, stray);
      check("R3", "counter cleared by rewrite", n, period_of(5'd0));

      // R4 correct key
      repeat (10) @(negedge clk);
      bus_write(1'b1, KEY);
      check("R4", "key gives no pulse", irq_pulse_o, 0);
      wait_pulse(1'b0, 100, n, stray);
      check("R4", "key restarts period", n, period_of(5'd0));

      // R5 wrong key, R10 restart reads zero
      repeat (5) @(negedge clk);
      bus_write(1'b1, 8'h55);
      check("R5", "bad key forces irq", irq_pulse_o, 1);
      read_reg(1'b1, v);
      check("R10", "restart reads zero", v, 0);

      // R6 reset action with exponent 1
      do_reset();
      bus_write(1'b0, 8'hC1);
      wait_pulse(1'b1, 200, n, stray);
      check("R6", "reset action period e1", n, period_of(5'd1));
      check("R6", "reset action no irq", stray, 0);
      bus_write(1'b1, 8'hAD);
      check("R5", "bad key forces reset req", rst_pulse_o, 1);

      // R7 stop action
      do_reset();
      bus_write(1'b0, 8'h00);
      wait_pulse(1'b0, 300, n, stray);
      check("R7", "stop: no irq", n, 301);
      check("R7", "stop: no reset", stray, 0);
      bus_write(1'b0, 8'h20);
      check("R7", "stop: rewrite quiet", irq_pulse_o | rst_pulse_o, 0);
      bus_write(1'b1, 8'h00);
      check("R7", "stop: bad key quiet", irq_pulse_o | rst_pulse_o, 0);
      read_reg(1'b0, v);
      check("R7", "stop: cfg unchanged", v, 8'h00);
      check("R10", "lock held", lock_o, 1);
      do_reset();
      check("R10", "reset clears lock", lock_o, 0);

      // constrained random against a reference count
      void'($urandom(32'h5eed_0017));
      for (int it = 0; it < 40; it++) begin
         logic [7:0] cfg;
         logic [1:0] act;
         int per, mcnt, mism;
         logic e_irq, e_rst;
         do_reset();
         cfg = 8'($urandom);
         cfg[4:0] = 5'($urandom_range(0, 2));
         act = cfg[6:5];
         per = period_of(cfg[4:0]);
         bus_write(1'b0, cfg);
         mcnt = 0;
         mism = 0;
         e_irq = 1'b0;
         e_rst = 1'b0;
         for (int c = 0; c < 300; c++) begin
            int r;
            logic forced, nat, evt, touch;
            if (irq_pulse_o !== e_irq || rst_pulse_o !== e_rst) begin
               if (mism == 0)
                  $display("FAIL R8 random it=%0d cyc=%0d actual=%b%b expected=%b%b",
                           it, c, irq_pulse_o, rst_pulse_o, e_irq, e_rst);
               mism++;
            end
            r = $urandom_range(0, 99);
            reg_wr = 1'b0;
            forced = 1'b0;
            touch  = 1'b0;
            if (r < 6) begin
               reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = KEY; touch = 1'b1;
            end else if (r < 9) begin
               reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'($urandom_range(0, 170));
               touch = 1'b1; forced = 1'b1;
            end else if (r < 11) begin
               reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'($urandom);
               touch = 1'b1; forced = 1'b1;
            end
            forced = forced && (act != 2'b00);
            nat    = (act != 2'b00) && (mcnt == per - 1);
            evt    = forced || nat;
            e_irq  = exp_irq(act, evt);
            e_rst  = exp_rst(act, evt);
            if (touch || evt) mcnt = 0;
            else if (act != 2'b00) mcnt++;
            @(negedge clk);
         end
         reg_wr = 1'b0;
         n_chk++;
         if (mism != 0) begin
            n_bad++;
            $display("FAIL R6 random it=%0d mismatches actual=%0d expected=0", it, mism);
         end
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule